// File: doc/BRIEF.md
# DRAM Command Bus Stretch and Drive Control

This block sits between the memory scheduler and the DRAM command/address pads. The scheduler hands it one command per cycle through a valid/ready pair. The block places the command, address and rank chip select on registered pins. It can hold each command for one, two or three clock cycles, so that slow, heavily loaded address lines have time to settle. Chip select is asserted only in the final cycle of that window. While a stretched command is still going out, ready stays low, so the scheduler cannot overlap commands.

The block also drives the pad output-enable under one of two policies. In the power-aware policy, the bus is released to high impedance when every rank has its clock enable off or when memory is in self-refresh or a deeper state. Otherwise it is driven, and idle cycles carry a no-operation encoding. In the always-drive policy, the enable never drops, and idle cycles repeat the last command and address with chip select deasserted.

The two mode fields are captured into internal state only while no command is in flight. After reset this state holds the two-cycle stretch and the power-aware policy.

Top module: `cmd_bus_drv`

## Requirements
- R1: Stretch code 2'b00 gives a one-cycle command, 2'b10 two cycles, 2'b11 three cycles. During that window, cmd_o and addr_o hold the accepted values. Pins change on the clock edge that accepts the command.
- R2: The reserved stretch code 2'b01 behaves as the one-cycle code.
- R3: cs_no is active low, with bit k belonging to rank k. In each command, exactly the addressed bit is low, for one cycle only, and that cycle is the last cycle of the window. At most one bit is ever low.
- R4: ready_o is low in every window cycle except the last. A command is accepted on any edge with valid_i and ready_o both high, so one-cycle commands can follow each other on consecutive edges.
- R5: The mode fields are captured on an edge only when no command is in flight. A code change made during a window does not alter that window. The new code applies to commands accepted after the next capture edge.
- R6: Reset gives ready_o=1, cs_no all ones, oe_o=0 and cmd_o=3'b111. The captured mode is two-cycle stretch with the power-aware policy, so a command accepted on the first edge after reset lasts two cycles whatever the stretch input is.
- R7: Under the power-aware policy, oe_o goes low after an idle edge on which all cke_off_i bits are high or self_refresh_i is high. oe_o is high after an edge on which neither holds.
- R8: Under the power-aware policy, an idle edge sets every cs_no bit high and cmd_o to the no-operation value 3'b111.
- R9: Under the always-drive policy, oe_o stays high. An idle edge keeps cmd_o and addr_o at the last command's values, with every cs_no bit high.
- R10: oe_o is high in every cycle of a command window, whatever the low-power inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DRAM command clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Scheduler has a command |
| ready_o | output | 1 | Block can accept a command this edge |
| cmd_i | input | CMD_W | Command encoding from the scheduler |
| addr_i | input | ADDR_W | Address and bank bits |
| rank_i | input | RANK_W | Target rank |
| stretch_code_i | input | 2 | Command stretch code |
| always_drive_i | input | 1 | 1 selects the always-drive policy |
| cke_off_i | input | NUM_RANKS | Per-rank clock-enable-off status |
| self_refresh_i | input | 1 | Memory in self-refresh or deeper |
| cmd_o | output | CMD_W | Command pins |
| addr_o | output | ADDR_W | Address pins |
| cs_no | output | NUM_RANKS | Active-low chip selects |
| oe_o | output | 1 | Pad output-enable |

## Verification
The assertions assume that rank_i addresses an existing rank, and that the scheduler raises valid_i only while the bus policy allows commands. They also assume that a request held against a low ready_o is simply stalled and not withdrawn. The stimulus drives inputs only on falling edges. It changes mode fields while idle, except in the one test that deliberately changes the stretch code mid-window. It issues a command under low-power status only to show that the enable stays up for the whole window.

// File: rtl/cmd_bus_pkg.sv
package cmd_bus_pkg;

  typedef enum logic [1:0] {
    STR_1N  = 2'b00,
    STR_RSV = 2'b01,
    STR_2N  = 2'b10,
    STR_3N  = 2'b11
  } stretch_e;

  localparam int unsigned MAX_SPAN = 3;
  localparam int unsigned SPAN_W   = $clog2(MAX_SPAN + 1);

  // reserved code falls back to single-cycle timing
  function automatic logic [SPAN_W-1:0] span_of(stretch_e code);
    case (code)
      STR_2N:  span_of = SPAN_W'(2);
      STR_3N:  span_of = SPAN_W'(3);
      default: span_of = SPAN_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/cmd_mode_reg.sv
module cmd_mode_reg
  import cmd_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic [1:0]        stretch_code_i,
  input  logic              always_drive_i,
  output logic [SPAN_W-1:0] span_o,
  output logic              drive_q_o
);

  stretch_e str_q;
  logic     drv_q;

  // fields only move between commands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      str_q <= STR_2N;
      drv_q <= 1'b0;
    end else if (idle_i) begin
      str_q <= stretch_e'(stretch_code_i);
      drv_q <= always_drive_i;
    end
  end

  assign span_o    = span_of(str_q);
  assign drive_q_o = drv_q;

endmodule

// File: rtl/cmd_stretch_seq.sv
module cmd_stretch_seq
  import cmd_bus_pkg::*;
#(
  parameter int unsigned      CMD_W     = 3,
  parameter int unsigned      ADDR_W    = 17,
  parameter int unsigned      NUM_RANKS = 2,
  parameter logic [CMD_W-1:0] NOP_CMD   = '1,
  localparam int unsigned     RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [CMD_W-1:0]     cmd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [RANK_W-1:0]    rank_i,
  input  logic [SPAN_W-1:0]    span_i,
  input  logic                 hold_idle_i,
  output logic                 ready_o,
  output logic                 busy_next_o,
  output logic [CMD_W-1:0]     cmd_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [NUM_RANKS-1:0] cs_no
);

  logic [SPAN_W-1:0]    cnt_q;
  logic [RANK_W-1:0]    rank_q;
  logic [CMD_W-1:0]     cmd_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [NUM_RANKS-1:0] cs_q;
  logic [NUM_RANKS-1:0] sel_new;
  logic [NUM_RANKS-1:0] sel_held;
  logic                 accept;
  logic                 in_window;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank_dec
    assign sel_new[r]  = (rank_i == RANK_W'(r));
    assign sel_held[r] = (rank_q == RANK_W'(r));
  end

  assign in_window   = (cnt_q != '0);
  assign ready_o     = !in_window;
  assign accept      = valid_i && ready_o;
  assign busy_next_o = accept || in_window;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rank_q <= '0;
      cmd_q  <= NOP_CMD;
      addr_q <= '0;
      cs_q   <= '1;
    end else if (accept) begin
      cnt_q  <= span_i - SPAN_W'(1);
      rank_q <= rank_i;
      cmd_q  <= cmd_i;
      addr_q <= addr_i;
      cs_q   <= (span_i == SPAN_W'(1)) ? ~sel_new : '1;
    end else if (in_window) begin
      cnt_q <= cnt_q - SPAN_W'(1);
      // select only in the final cycle of the window
      cs_q  <= (cnt_q == SPAN_W'(1)) ? ~sel_held : '1;
    end else begin
      cs_q <= '1;
      if (!hold_idle_i) cmd_q <= NOP_CMD;
    end
  end

  assign cmd_o  = cmd_q;
  assign addr_o = addr_q;
  assign cs_no  = cs_q;

endmodule

// File: rtl/bus_oe_ctrl.sv
module bus_oe_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_next_i,
  input  logic drive_q_i,
  input  logic lp_state_i,
  output logic oe_o
);

  logic oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= busy_next_i || drive_q_i || !lp_state_i;
  end

  assign oe_o = oe_q;

endmodule

// File: rtl/cmd_bus_drv.sv
module cmd_bus_drv
  import cmd_bus_pkg::*;
#(
  parameter int unsigned      CMD_W     = 3,
  parameter int unsigned      ADDR_W    = 17,
  parameter int unsigned      NUM_RANKS = 2,
  parameter logic [CMD_W-1:0] NOP_CMD   = '1,
  localparam int unsigned     RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  output logic                 ready_o,
  input  logic [CMD_W-1:0]     cmd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [RANK_W-1:0]    rank_i,
  input  logic [1:0]           stretch_code_i,
  input  logic                 always_drive_i,
  input  logic [NUM_RANKS-1:0] cke_off_i,
  input  logic                 self_refresh_i,
  output logic [CMD_W-1:0]     cmd_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [NUM_RANKS-1:0] cs_no,
  output logic                 oe_o
);

  logic [SPAN_W-1:0] span;
  logic              mode_drive_q;
  logic              busy_next;
  logic              lp_state;

  assign lp_state = (&cke_off_i) || self_refresh_i;

  cmd_mode_reg u_mode (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .idle_i         (ready_o),
    .stretch_code_i (stretch_code_i),
    .always_drive_i (always_drive_i),
    .span_o         (span),
    .drive_q_o      (mode_drive_q)
  );

  cmd_stretch_seq #(
    .CMD_W     (CMD_W),
    .ADDR_W    (ADDR_W),
    .NUM_RANKS (NUM_RANKS),
    .NOP_CMD   (NOP_CMD)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .cmd_i       (cmd_i),
    .addr_i      (addr_i),
    .rank_i      (rank_i),
    .span_i      (span),
    .hold_idle_i (mode_drive_q),
    .ready_o     (ready_o),
    .busy_next_o (busy_next),
    .cmd_o       (cmd_o),
    .addr_o      (addr_o),
    .cs_no       (cs_no)
  );

  bus_oe_ctrl u_oe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_next_i (busy_next),
    .drive_q_i   (mode_drive_q),
    .lp_state_i  (lp_state),
    .oe_o        (oe_o)
  );

endmodule

// File: rtl/cmd_bus_drv_chk.sv
module cmd_bus_drv_chk #(
  parameter int unsigned      CMD_W     = 3,
  parameter int unsigned      ADDR_W    = 17,
  parameter int unsigned      NUM_RANKS = 2,
  parameter logic [CMD_W-1:0] NOP_CMD   = '1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic                 ready_o,
  input logic [CMD_W-1:0]     cmd_o,
  input logic [ADDR_W-1:0]    addr_o,
  input logic [NUM_RANKS-1:0] cs_no,
  input logic                 oe_o,
  input logic                 mode_drive_q,
  input logic                 lp_state
);

  AST_STABLE_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ($stable(cmd_o) && $stable(addr_o))); // R1

  AST_NO_CS_BEFORE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (&cs_no)); // R3

  AST_CS_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no)); // R3

  AST_LP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_drive_q && ready_o && !valid_i && lp_state) |=> !oe_o); // R7

  AST_ACTIVE_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lp_state |=> oe_o); // R7

  AST_IDLE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_drive_q && ready_o && !valid_i) |=> ((cmd_o == NOP_CMD) && (&cs_no))); // R8

  AST_ALWAYS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_drive_q |=> oe_o); // R9

  AST_CS_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cs_no) |-> oe_o); // R10

endmodule

bind cmd_bus_drv cmd_bus_drv_chk #(
  .CMD_W     (CMD_W),
  .ADDR_W    (ADDR_W),
  .NUM_RANKS (NUM_RANKS),
  .NOP_CMD   (NOP_CMD)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .ready_o      (ready_o),
  .cmd_o        (cmd_o),
  .addr_o       (addr_o),
  .cs_no        (cs_no),
  .oe_o         (oe_o),
  .mode_drive_q (mode_drive_q),
  .lp_state     (lp_state)
);

// File: tb/cmd_bus_drv_tb.sv
module cmd_bus_drv_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CMD_W      = 3;
  localparam int ADDR_W     = 17;
  localparam int NR         = 2;
  localparam logic [CMD_W-1:0] NOP = 3'b111;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic              ready_o;
  logic [CMD_W-1:0]  cmd_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [0:0]        rank_i = '0;
  logic [1:0]        stretch_code_i = 2'b00;
  logic              always_drive_i = 1'b0;
  logic [NR-1:0]     cke_off_i = '0;
  logic              self_refresh_i = 1'b0;
  logic [CMD_W-1:0]  cmd_o;
  logic [ADDR_W-1:0] addr_o;
  logic [NR-1:0]     cs_no;
  logic              oe_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cmd_bus_drv u_dut (
    .clk_i, .rst_ni, .valid_i, .ready_o, .cmd_i, .addr_i, .rank_i,
    .stretch_code_i, .always_drive_i, .cke_off_i, .self_refresh_i,
    .cmd_o, .addr_o, .cs_no, .oe_o
  );

  typedef struct packed {
    logic [1:0]        code;
    logic [1:0]        span;
    logic              rank;
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'b00, 2'd1, 1'b0, 3'b011, 17'h00123},
    '{2'b10, 2'd2, 1'b1, 3'b101, 17'h1abcd},
    '{2'b11, 2'd3, 1'b0, 3'b100, 17'h05555},
    '{2'b01, 2'd1, 1'b1, 3'b110, 17'h0aaaa},
    '{2'b11, 2'd3, 1'b1, 3'b010, 17'h1ffff},
    '{2'b10, 2'd2, 1'b0, 3'b001, 17'h00000}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NR-1:0] cs_of(input logic r);
    return ~(NR'(1) << r);
  endfunction

  // called at a falling edge; returns at the falling edge inside the last window cycle
  task automatic issue(input string req, input logic r, input logic [CMD_W-1:0] c,
                       input logic [ADDR_W-1:0] a, input int span);
    valid_i = 1'b1; rank_i = r; cmd_i = c; addr_i = a;
    chk(req, "ready before issue", 32'(ready_o), 32'd1);
    @(negedge clk_i);
    valid_i = 1'b0;
    for (int k = 1; k <= span; k++) begin
      chk(req, "cmd pins", 32'(cmd_o), 32'(c));
      chk(req, "addr pins", 32'(addr_o), 32'(a));
      chk("R3", "chip select", 32'(cs_no), (k == span) ? 32'(cs_of(r)) : 32'(NR'('1)));
      chk("R4", "ready in window", 32'(ready_o), (k == span) ? 32'd1 : 32'd0);
      chk("R10", "oe in window", 32'(oe_o), 32'd1);
      if (k < span) @(negedge clk_i);
    end
  endtask

  task automatic set_mode(input logic [1:0] code, input logic drv);
    stretch_code_i = code; always_drive_i = drv;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R6: reset values, with valid and a 1N code already present
    stretch_code_i = 2'b00; valid_i = 1'b1; cmd_i = 3'b011; addr_i = 17'h00777; rank_i = 1'b1;
    #(CLK_PERIOD*2);
    chk("R6", "reset ready", 32'(ready_o), 32'd1);
    chk("R6", "reset cs", 32'(cs_no), 32'(NR'('1)));
    chk("R6", "reset oe", 32'(oe_o), 32'd0);
    chk("R6", "reset cmd", 32'(cmd_o), 32'(NOP));
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); valid_i = 1'b0;
    chk("R6", "first cmd uses 2N: ready", 32'(ready_o), 32'd0);
    chk("R6", "first cmd uses 2N: cs", 32'(cs_no), 32'(NR'('1)));
    @(negedge clk_i);
    chk("R6", "first cmd 2N last cycle cs", 32'(cs_no), 32'(cs_of(1'b1)));
    chk("R6", "first cmd cmd held", 32'(cmd_o), 32'h3);
    @(negedge clk_i);
    chk("R8", "idle nop", 32'(cmd_o), 32'(NOP));

    // R1 R2: table walk
    for (int i = 0; i < 6; i++) begin
      set_mode(VECS[i].code, 1'b0);
      issue((VECS[i].code == 2'b01) ? "R2" : "R1", VECS[i].rank, VECS[i].cmd,
            VECS[i].addr, int'(VECS[i].span));
      @(negedge clk_i);
      chk("R8", "idle cs after cmd", 32'(cs_no), 32'(NR'('1)));
      chk("R8", "idle nop after cmd", 32'(cmd_o), 32'(NOP));
    end

    // R4: back-to-back 1N
    set_mode(2'b00, 1'b0);
    issue("R4", 1'b0, 3'b011, 17'h00011, 1);
    issue("R4", 1'b1, 3'b101, 17'h00022, 1);
    issue("R4", 1'b0, 3'b100, 17'h00033, 1);
    @(negedge clk_i);

    // R5: code change inside a 3N window does not alter it
    set_mode(2'b11, 1'b0);
    valid_i = 1'b1; rank_i = 1'b1; cmd_i = 3'b110; addr_i = 17'h01234;
    @(negedge clk_i);
    valid_i = 1'b0; stretch_code_i = 2'b00;
    chk("R5", "window cycle1 ready", 32'(ready_o), 32'd0);
    @(negedge clk_i);
    chk("R5", "window cycle2 ready", 32'(ready_o), 32'd0);
    chk("R5", "window cycle2 cs", 32'(cs_no), 32'(NR'('1)));
    @(negedge clk_i);
    chk("R5", "window cycle3 cs", 32'(cs_no), 32'(cs_of(1'b1)));
    @(negedge clk_i);
    issue("R5", 1'b0, 3'b011, 17'h00042, 1);
    @(negedge clk_i);

    // R7: power-aware release
    cke_off_i = 2'b11;
    @(negedge clk_i);
    chk("R7", "all cke off floats", 32'(oe_o), 32'd0);
    cke_off_i = 2'b01;
    @(negedge clk_i);
    chk("R7", "one rank awake drives", 32'(oe_o), 32'd1);
    self_refresh_i = 1'b1;
    @(negedge clk_i);
    chk("R7", "self refresh floats", 32'(oe_o), 32'd0);
    // R10: window under low-power status stays driven
    set_mode(2'b10, 1'b0);
    issue("R10", 1'b1, 3'b001, 17'h00aa5, 2);
    @(negedge clk_i);
    chk("R7", "float again after window", 32'(oe_o), 32'd0);
    self_refresh_i = 1'b0; cke_off_i = 2'b00;
    @(negedge clk_i);

    // R9: always-drive policy keeps last command, enable high
    set_mode(2'b00, 1'b1);
    issue("R9", 1'b0, 3'b010, 17'h0beef, 1);
    cke_off_i = 2'b11; self_refresh_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R9", "oe held in low power", 32'(oe_o), 32'd1);
    chk("R9", "cmd repeated", 32'(cmd_o), 32'h2);
    chk("R9", "addr repeated", 32'(addr_o), 32'h0beef);
    chk("R9", "cs deasserted", 32'(cs_no), 32'(NR'('1)));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule